// File: doc/BRIEF.md
# Gated Software Event Trigger

This block lets software start event lines by writing a register. There are seventeen event lines. Writing a one to the bit of a line produces a pulse of one clock cycle on that line. The pulse comes out in the cycle after the write, and the trigger bits clear themselves. Each bus write carries a security attribute and a privilege attribute. Two per-line configuration vectors decide which attributes a line accepts. The check is made line by line, so a line that is not allowed drops its part of the write without any sign. A read returns zero for every access and attribute.

The software pulses are also merged with hardware edge events into a pending vector. A hardware input sets its pending bit on a rising edge when the rise select of that line is set, and on a falling edge when its fall select is set. A software pulse sets the pending bit whatever the two selects are. Software clears pending bits with a per-line clear strobe. The block sits behind an address decoder that already produces the select.

Top module: `evt_swtrig`

## Requirements
- R1: A write (sel_i=1, we_i=1) with wdata_i bit i = 1 for i in 0..16, and access allowed, drives swi_pulse_o[i] high for exactly the one cycle after the write.
- R2: Bits of wdata_i that are 0, bits 31..17 of wdata_i, and cycles with sel_i=0 or we_i=0 produce no pulse.
- R3: When sec_cfg_i[i]=1, a write with sec_i=0 has no effect on line i. When sec_cfg_i[i]=0, writes with sec_i=0 and with sec_i=1 are both accepted.
- R4: When priv_cfg_i[i]=1, a write with priv_i=0 has no effect on line i. When priv_cfg_i[i]=0, writes with priv_i=0 and with priv_i=1 are both accepted.
- R5: The security and privilege checks apply to each line on its own. A line fires only if it passes both checks, so one write may fire some lines and drop others.
- R6: Accepted writes to the same line in consecutive cycles produce pulses in consecutive cycles.
- R7: rdata_o is zero in every cycle, for any access and any attributes.
- R8: A software pulse on line i sets pend_o[i] in the cycle after the pulse, whatever rise_en_i and fall_en_i are.
- R9: A 0-to-1 change of hw_evt_i[i] sets pend_o[i] at the next clock edge when rise_en_i[i]=1. A 1-to-0 change sets it when fall_en_i[i]=1. With the matching select at 0, the change does nothing.
- R10: pend_clr_i[i]=1 clears pend_o[i] at the next edge. If a set and a clear of the same line fall in the same cycle, the set wins.
- R11: While rst_ni is low, swi_pulse_o and pend_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register selected by the address decoder |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data, one trigger bit per line |
| sec_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | 32 | Read data, always zero |
| sec_cfg_i | input | 17 | Per-line secure-only configuration |
| priv_cfg_i | input | 17 | Per-line privileged-only configuration |
| hw_evt_i | input | 17 | Synchronous hardware event levels |
| rise_en_i | input | 17 | Per-line rising edge select |
| fall_en_i | input | 17 | Per-line falling edge select |
| pend_clr_i | input | 17 | Per-line pending clear strobe |
| swi_pulse_o | output | 17 | Software event pulses |
| pend_o | output | 17 | Pending event vector |

## Verification
A wrong gate term shows up on swi_pulse_o one cycle after the write that should have been dropped or accepted. The bench compares that cycle against a table of attribute and configuration patterns. A trigger bit that does not clear itself shows up as a pulse that is still high on the second cycle. A bad set-or-clear priority in the pending logic shows up on pend_o one cycle after the colliding strobes. A lost hardware edge shows up on pend_o at the next sample point.

// File: rtl/evt_swtrig_pkg.sv
package evt_swtrig_pkg;
  localparam int unsigned N_LINES = 17;
  localparam int unsigned BUS_DW  = 32;
  typedef logic [N_LINES-1:0] line_vec_t;
endpackage

// File: rtl/evt_swtrig_gate.sv
module evt_swtrig_gate #(
  parameter int unsigned N  = 17,
  parameter int unsigned DW = 32
) (
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sec_i,
  input  logic          priv_i,
  input  logic [N-1:0]  sec_cfg_i,
  input  logic [N-1:0]  priv_cfg_i,
  output logic [N-1:0]  accept_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^wdata_i[DW-1:N];

  for (genvar i = 0; i < N; i++) begin : g_line
    logic sec_ok, priv_ok;
    assign sec_ok      = sec_i  | ~sec_cfg_i[i];
    assign priv_ok     = priv_i | ~priv_cfg_i[i];
    assign accept_o[i] = wr_en_i & wdata_i[i] & sec_ok & priv_ok;
  end
endmodule

// File: rtl/evt_swtrig_pulse.sv
module evt_swtrig_pulse #(
  parameter int unsigned N = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] accept_i,
  output logic [N-1:0] pulse_o
);
  // trigger bits self-clear: register holds only this cycle's accepts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= '0;
    else         pulse_o <= accept_i;
  end
endmodule

// File: rtl/evt_swtrig_pend.sv
module evt_swtrig_pend #(
  parameter int unsigned N = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sw_pulse_i,
  input  logic [N-1:0] hw_evt_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] hw_q, set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hw_q <= '0;
    else         hw_q <= hw_evt_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall;
    assign rise   = hw_evt_i[i] & ~hw_q[i] & rise_en_i[i];
    assign fall   = ~hw_evt_i[i] & hw_q[i] & fall_en_i[i];
    assign set[i] = sw_pulse_i[i] | rise | fall;

    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_o[i] <= 1'b0;
      else if (set[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
    // R10
    pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !sw_pulse_i[i] && !rise_en_i[i] && !fall_en_i[i]) |=> !pend_o[i]);
    // R8
    pend_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_pulse_i[i] |=> pend_o[i]);
  end
endmodule

// File: rtl/evt_swtrig.sv
module evt_swtrig
  import evt_swtrig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic              sec_i,
  input  logic              priv_i,
  output logic [BUS_DW-1:0] rdata_o,
  input  line_vec_t         sec_cfg_i,
  input  line_vec_t         priv_cfg_i,
  input  line_vec_t         hw_evt_i,
  input  line_vec_t         rise_en_i,
  input  line_vec_t         fall_en_i,
  input  line_vec_t         pend_clr_i,
  output line_vec_t         swi_pulse_o,
  output line_vec_t         pend_o
);
  line_vec_t accept;

  // reads never expose trigger or pending state
  assign rdata_o = '0;

  evt_swtrig_gate #(.N(N_LINES), .DW(BUS_DW)) u_gate (
    .wr_en_i    (sel_i & we_i),
    .wdata_i    (wdata_i),
    .sec_i      (sec_i),
    .priv_i     (priv_i),
    .sec_cfg_i  (sec_cfg_i),
    .priv_cfg_i (priv_cfg_i),
    .accept_o   (accept)
  );

  evt_swtrig_pulse #(.N(N_LINES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .pulse_o  (swi_pulse_o)
  );

  evt_swtrig_pend #(.N(N_LINES)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_pulse_i (swi_pulse_o),
    .hw_evt_i   (hw_evt_i),
    .rise_en_i  (rise_en_i),
    .fall_en_i  (fall_en_i),
    .clr_i      (pend_clr_i),
    .pend_o     (pend_o)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    // R1
    pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swi_pulse_o[i] |-> $past(sel_i && we_i && wdata_i[i]));
    // R3
    sec_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swi_pulse_o[i] |-> $past(sec_i || !sec_cfg_i[i]));
    // R4
    priv_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swi_pulse_o[i] |-> $past(priv_i || !priv_cfg_i[i]));
  end
endmodule

// File: tb/evt_swtrig_tb.sv
module evt_swtrig_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 17;

  typedef struct packed {
    logic [NL-1:0] sec_cfg;
    logic [NL-1:0] priv_cfg;
    logic          sec;
    logic          priv;
    logic [31:0]   wdata;
    logic [NL-1:0] exp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{17'h00000, 17'h00000, 1'b0, 1'b0, 32'h0001_FFFF, 17'h1FFFF}, // R1 R3 R4
    '{17'h00000, 17'h00000, 1'b1, 1'b1, 32'hFFFE_0000, 17'h00000}, // R2
    '{17'h1FFFF, 17'h00000, 1'b0, 1'b1, 32'h0001_FFFF, 17'h00000}, // R3
    '{17'h1FFFF, 17'h00000, 1'b1, 1'b0, 32'h0000_0005, 17'h00005}, // R3
    '{17'h00000, 17'h1FFFF, 1'b1, 1'b0, 32'h0001_FFFF, 17'h00000}, // R4
    '{17'h00000, 17'h1FFFF, 1'b0, 1'b1, 32'h0001_0001, 17'h10001}, // R4
    '{17'h000FF, 17'h0FF00, 1'b0, 1'b0, 32'h0001_FFFF, 17'h10000}, // R5
    '{17'h000FF, 17'h0FF00, 1'b1, 1'b0, 32'h0001_FFFF, 17'h100FF}  // R5
  };

  logic clk = 0, rst_n = 0;
  logic sel = 0, we = 0, sec = 0, priv = 0;
  logic [31:0] wdata = '0, rdata;
  logic [NL-1:0] sec_cfg = '0, priv_cfg = '0, hw = '0, ren = '0, fen = '0, clr = '0;
  logic [NL-1:0] pulse, pend;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_swtrig u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .sec_i(sec), .priv_i(priv), .rdata_o(rdata), .sec_cfg_i(sec_cfg),
    .priv_cfg_i(priv_cfg), .hw_evt_i(hw), .rise_en_i(ren), .fall_en_i(fen),
    .pend_clr_i(clr), .swi_pulse_o(pulse), .pend_o(pend)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk("R11 pulse", 32'(pulse), 0);
    chk("R11 pend", 32'(pend), 0);
    rst_n = 1;
    step();

    foreach (TBL[k]) begin
      sec_cfg = TBL[k].sec_cfg; priv_cfg = TBL[k].priv_cfg;
      sec = TBL[k].sec; priv = TBL[k].priv; wdata = TBL[k].wdata;
      sel = 1; we = 1;
      step();
      chk("R7 rdata on write", rdata, 0);
      sel = 0; we = 0;
      chk("R1/R2/R3/R4/R5 pulse", 32'(pulse), 32'(TBL[k].exp));
      step();
      chk("R1 single cycle", 32'(pulse), 0);
    end
    sec_cfg = '0; priv_cfg = '0;

    // R2: we low or sel low
    wdata = 32'h1FFFF; sel = 1; we = 0; step();
    sel = 0; we = 1; step();
    we = 0; chk("R2 no strobe", 32'(pulse), 0);
    // R7: read with secure privileged
    sec = 1; priv = 1; sel = 1; step();
    chk("R7 read", rdata, 0);
    sel = 0;
    clr = '1; step(); step(); clr = '0;
    chk("R10 clear all", 32'(pend), 0);

    // R6: back-to-back
    wdata = 32'h8; sel = 1; we = 1; step();
    chk("R6 first", 32'(pulse), 32'h8);
    step();
    sel = 0; we = 0;
    chk("R6 second", 32'(pulse), 32'h8);
    // R8: pending set with selects off
    chk("R8 pend", 32'(pend), 32'h8);
    step();
    chk("R6 end", 32'(pulse), 0);
    clr = 17'h8; step(); clr = '0;
    chk("R10 clear", 32'(pend), 0);

    // R10: set wins over clear
    wdata = 32'h2; sel = 1; we = 1; step();
    sel = 0; we = 0; clr = 17'h2; step();
    chk("R10 set wins", 32'(pend), 32'h2);
    step(); clr = '0;
    chk("R10 clear after", 32'(pend), 0);

    // R9: hardware edges
    ren = 17'h1; fen = 17'h4;
    hw = 17'h5; step();
    chk("R9 rise", 32'(pend), 32'h1);
    hw = 17'h0; step();
    chk("R9 fall", 32'(pend), 32'h5);
    clr = '1; step(); clr = '0;
    ren = 17'h0; fen = 17'h0;
    hw = 17'h5; step();
    hw = 17'h0; step();
    chk("R9 disabled", 32'(pend), 0);

    // R11: async reset clears pending
    ren = 17'h1; hw = 17'h1; step();
    chk("R9 rise again", 32'(pend), 32'h1);
    #1 rst_n = 0; #1;
    chk("R11 reset pend", 32'(pend), 0);
    step(); rst_n = 1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule